// File: doc/BRIEF.md
# Write-Once Flash Page Buffer

This block is the staging store that sits between a flash fill command and the flash programming sequencer. Software loads a page one 16-bit instruction word at a time, each write carrying a word index within the page. Once the page is complete, the sequencer reads every word back through an indexed read port and programs it into the array. Words that were never loaded read back as the erased value 0xFFFF. A per-word valid bit records which locations hold data.

Each location accepts one write per erase cycle. Any later write to the same location is dropped, and a one-cycle flag reports the rejected attempt. The whole buffer is wiped at once by any of four unrelated events: completion of a page write, the read-while-write re-enable command, system reset, and EEPROM write activity that happens while words are loaded. The page size is a parameter, and the index width is derived from it.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, every index reads 0xFFFF on `rd_data` and `rd_valid` is 0.
- R2: A write (`wr_en` high) to an index whose valid bit is clear stores `wr_data`. From the cycle after the write's clock edge, that index reads the stored word and `rd_valid` is 1.
- R3: A write to an index whose valid bit is already set leaves the stored word unchanged.
- R4: `wr_reject` is high for exactly the one cycle after a write that was dropped under R3. It is low in all other cycles.
- R5: A pulse on `clr_page_done` makes every index read 0xFFFF with `rd_valid` 0 from the next cycle on. Afterwards each index accepts one new write.
- R6: A pulse on `clr_rww_en` clears the buffer in the same way as R5.
- R7: A pulse on `ee_wr` (EEPROM write activity) discards all loaded words in the same way as R5.
- R8: When any clear input is high in the same cycle as a write, the clear wins. The write is not stored and `wr_reject` stays low.
- R9: A write changes only the addressed index. All other indices keep their value and valid state.
- R10: The read port is combinational. `rd_data` and `rd_valid` follow `rd_idx` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Word write strobe from the fill command |
| wr_idx | input | IDX_W | Word index within the page |
| wr_data | input | WORD_W | Instruction word to load |
| clr_page_done | input | 1 | Page write completed |
| clr_rww_en | input | 1 | Read-while-write re-enable command |
| ee_wr | input | 1 | EEPROM write activity |
| rd_idx | input | IDX_W | Read index from the programming sequencer |
| rd_data | output | WORD_W | Word at rd_idx, or 0xFFFF if not loaded |
| rd_valid | output | 1 | Word at rd_idx has been loaded |
| wr_reject | output | 1 | Previous cycle's write was dropped as a duplicate |

## Verification
The bench aims at a second write to a loaded index. A design that lets that write through would show the new word on the read port instead of the first one, and would miss the reject flag. It also fires clear events in the same cycle as writes. A design that ranks the write above the clear would leave a stale valid word after the wipe, or would raise a false reject. Full read sweeps after every kind of clear catch a design that misses one clear source, that fails to return erased words as 0xFFFF, or whose write decode spills into a neighbouring index, most likely at index 0 or at the last index.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam int unsigned DEF_PAGE_WORDS = 128;
  localparam int unsigned DEF_WORD_W     = 16;

  typedef struct packed {
    logic page_done;
    logic rww_en;
    logic ee_wr;
  } clr_src_t;

  function automatic logic any_clear(clr_src_t s);
    return s.page_done | s.rww_en | s.ee_wr;
  endfunction
endpackage

// File: rtl/pgbuf_rst_sync.sv
module pgbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pgbuf_track.sv
module pgbuf_track #(
  parameter int unsigned PAGE_WORDS = 128,
  localparam int unsigned IDX_W = $clog2(PAGE_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  clr,
  output logic                  accept,
  output logic [PAGE_WORDS-1:0] valid_q,
  output logic                  reject_q
);
  logic [PAGE_WORDS-1:0] valid_d;
  logic                  hit;
  logic                  reject_d;

  // next state
  always_comb begin
    hit      = valid_q[wr_idx];
    accept   = wr_en & ~clr & ~hit;
    reject_d = wr_en & ~clr & hit;
    valid_d  = valid_q;
    if (clr)         valid_d = '0;
    else if (accept) valid_d[wr_idx] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      reject_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      reject_q <= reject_d;
    end
  end
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int unsigned PAGE_WORDS = 128,
  parameter int unsigned WORD_W     = 16,
  localparam int unsigned IDX_W = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              accept,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [PAGE_WORDS];

  for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
    logic we;
    assign we = accept && (wr_idx == IDX_W'(i));
    // data storage needs no reset: the valid mask hides it
    always_ff @(posedge clk) begin
      if (we) mem[i] <= wr_data;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top
  import pgbuf_pkg::*;
#(
  parameter int unsigned PAGE_WORDS = DEF_PAGE_WORDS,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  localparam int unsigned IDX_W = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_page_done,
  input  logic              clr_rww_en,
  input  logic              ee_wr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              wr_reject
);
  logic                  rst_n_sync;
  clr_src_t              clr_src;
  logic                  clr_all;
  logic                  accept;
  logic [PAGE_WORDS-1:0] valid_vec;
  logic [WORD_W-1:0]     rd_word;

  assign clr_src = '{page_done: clr_page_done, rww_en: clr_rww_en, ee_wr: ee_wr};
  assign clr_all = any_clear(clr_src);

  pgbuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pgbuf_track #(.PAGE_WORDS(PAGE_WORDS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .clr      (clr_all),
    .accept   (accept),
    .valid_q  (valid_vec),
    .reject_q (wr_reject)
  );

  pgbuf_store #(.PAGE_WORDS(PAGE_WORDS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .accept  (accept),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  assign rd_valid = valid_vec[rd_idx];
  assign rd_data  = rd_valid ? rd_word : {WORD_W{1'b1}};
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int unsigned PAGE_WORDS = 128,
  localparam int unsigned IDX_W = $clog2(PAGE_WORDS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic                  clr_page_done,
  input logic                  clr_rww_en,
  input logic                  ee_wr,
  input logic                  wr_reject,
  input logic [PAGE_WORDS-1:0] valid_vec
);
  logic clr_in;
  assign clr_in = clr_page_done | clr_rww_en | ee_wr;

  // R2
  a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_in) |=> valid_vec[$past(wr_idx)]);

  // R4
  a_r4_reject_needs_dup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_reject) |-> ($past(wr_en) && !$past(clr_in)));

  // R5 R6 R7
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in |=> (valid_vec == '0));

  // R8
  a_r8_clear_beats_reject: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in |=> !wr_reject);

  // R9
  a_r9_one_bit_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_in |=> ($countones(valid_vec) <= $countones($past(valid_vec)) + 1));
endmodule

bind pgbuf_top pgbuf_chk #(.PAGE_WORDS(PAGE_WORDS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .clr_page_done (clr_page_done),
  .clr_rww_en    (clr_rww_en),
  .ee_wr         (ee_wr),
  .wr_reject     (wr_reject),
  .valid_vec     (valid_vec)
);

// File: tb/sim_pgbuf_top.sv
`timescale 1ns/1ps
module sim_pgbuf_top;
  localparam int PW = 128;
  localparam int IW = $clog2(PW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [15:0]   wr_data = '0;
  logic          clr_page_done = 1'b0, clr_rww_en = 1'b0, ee_wr = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [15:0]   rd_data;
  logic          rd_valid, wr_reject;

  int checks = 0, failures = 0;
  string tag = "R1";

  // reference model
  logic [15:0] m_data [PW];
  bit          m_val  [PW];
  bit          m_rej;

  always #10 clk = ~clk;

  pgbuf_top #(.PAGE_WORDS(PW), .WORD_W(16)) u0 (.*);

  always @(posedge clk) begin
    bit c;
    c = clr_page_done | clr_rww_en | ee_wr;
    if (!rst_n) begin
      foreach (m_val[i]) m_val[i] = 0;
      m_rej = 0;
    end else begin
      m_rej = wr_en && !c && m_val[wr_idx];
      if (c) foreach (m_val[i]) m_val[i] = 0;
      else if (wr_en && !m_val[wr_idx]) begin
        m_val[wr_idx] = 1;
        m_data[wr_idx] = wr_data;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, {16'd0, rd_data}, {16'd0, m_val[rd_idx] ? m_data[rd_idx] : 16'hFFFF}, "rd_data");
    chk(req, {31'd0, rd_valid}, {31'd0, m_val[rd_idx]}, "rd_valid");
    chk(req, {31'd0, wr_reject}, {31'd0, m_rej}, "wr_reject");
  endtask

  // one clock; compare 5 ns after the edge, then inputs may change
  task automatic cyc();
    @(posedge clk); #5;
    compare(tag);
  endtask

  // R10: combinational read sweep, no clock edge in between
  task automatic sweep(string req);
    for (int i = 0; i < PW; i++) begin
      rd_idx = IW'(i); #0.1;
      compare(req);
    end
  endtask

  task automatic wr(int idx, logic [15:0] d);
    wr_en = 1; wr_idx = IW'(idx); wr_data = d; rd_idx = IW'(idx);
    cyc();
    wr_en = 0;
    cyc();
  endtask

  task automatic pulse(int which);
    clr_page_done = (which == 0); clr_rww_en = (which == 1); ee_wr = (which == 2);
    cyc();
    clr_page_done = 0; clr_rww_en = 0; ee_wr = 0;
    cyc();
  endtask

  task automatic fill(logic [15:0] base);
    for (int i = 0; i < PW; i += 9) wr(i, base + 16'(i));
    wr(PW - 1, base ^ 16'h5A5A);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (4) cyc();
    sweep("R1");
    tag = "R2"; wr(0, 16'h1234); wr(5, 16'hBEEF); wr(PW - 1, 16'h0001);
    tag = "R3"; wr(5, 16'h0000);
    tag = "R4"; wr_en = 1; wr_idx = 5; wr_data = 16'h7777; rd_idx = 5; cyc();
    wr_en = 0; chk("R4", {31'd0, wr_reject}, 32'd1, "reject pulse"); cyc();
    chk("R4", {31'd0, wr_reject}, 32'd0, "reject drops"); chk("R3", {16'd0, rd_data}, 32'hBEEF, "kept word");
    sweep("R9");
    tag = "R5"; pulse(0); sweep("R5");
    tag = "R5"; wr(5, 16'hCAFE); chk("R5", {16'd0, rd_data}, 32'hCAFE, "rewrite after clear");
    fill(16'h1000); tag = "R6"; pulse(1); sweep("R6");
    fill(16'h2000); tag = "R7"; pulse(2); sweep("R7");
    tag = "R8"; wr(3, 16'hAAAA);
    wr_en = 1; wr_idx = 3; wr_data = 16'hBBBB; ee_wr = 1; rd_idx = 3; cyc();
    wr_en = 1; wr_idx = 4; clr_rww_en = 1; ee_wr = 0; cyc();
    wr_en = 0; clr_rww_en = 0; cyc(); sweep("R8");
    tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      wr_en = (r < 60); wr_idx = IW'($urandom_range(0, PW - 1));
      wr_data = 16'($urandom);
      clr_page_done = (r == 97); clr_rww_en = (r == 98); ee_wr = (r == 99);
      cyc();
      rd_idx = IW'($urandom_range(0, PW - 1)); #0.1; compare("R10");
    end
    wr_en = 0; clr_page_done = 0; clr_rww_en = 0; ee_wr = 0;
    cyc(); sweep("R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule